// File: doc/BRIEF.md
# Flash Status Word Masked Update Sequencer

This block changes selected bits of the two 8-bit status registers of a serial flash device without disturbing the others. A caller presents a 16-bit mask, a 16-bit target value and a persistence choice, then pulses a start input. The sequencer reads both registers and joins them into one word. If the masked bits already hold the target it stops there. Otherwise it sends the matching write-enable command and one combined status write. It then waits until the write has taken effect and reads both registers back, so that a register held by the device's own protection is detected rather than silently assumed written.

The sequencer does not serialise bits onto the flash pins. It hands one command at a time to a separate command engine through a valid/ready request channel. Every request gets exactly one response beat from the engine, which may carry a read byte or a failure flag. When the sequence ends, a one-cycle done pulse appears together with error and locked flags, and those flags hold until the next accepted start.

Top module: `sreg_update_seq`

## Requirements
- R1: While reset is low and after it is released with no start, no command request is raised and the done, error and locked outputs are 0.
- R2: An accepted start issues a read of register 1 (opcode 05h, one response byte), then a read of register 2 (opcode 35h). The current word has register 1 in bits 7:0 and register 2 in bits 15:8.
- R3: When (current AND mask) equals (value AND mask), the sequence ends with done, no error and no further command, and the flash contents are untouched.
- R4: Otherwise a persistent update first sends the ordinary write enable (06h) and a volatile update sends the volatile write enable (50h), each with no data bytes.
- R5: The write is opcode 01h with two data bytes, where data bits 7:0 are sent first and belong to register 1, and the word equals (current AND NOT mask) OR (value AND mask).
- R6: After a persistent write the block re-reads register 1 (05h) until its bit 0 (busy) reads 0, then goes on to the verification reads.
- R7: If bit 0 still reads 1 on a poll response that arrives once POLL_TIMEOUT cycles have passed since the write response, the sequence ends with error set, locked clear and no verification reads.
- R8: After a volatile write no poll is issued, and the next command is accepted no sooner than DELAY_CYCLES cycles after the write response.
- R9: The verification reads are 05h then 35h. If the read-back word differs from the value in any masked bit, error and locked are both set. Otherwise both stay clear.
- R10: A response with the failure flag set ends the sequence at once with error set, locked clear and no further command.
- R11: A raised command request keeps its opcode and data unchanged until it is accepted, and no new request is raised before the response to the previous one.
- R12: Done is high for exactly one cycle per sequence. Error and locked hold their values until the next accepted start. A start that arrives while a sequence runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an update, sampled only when idle |
| mask_i | input | 16 | Bits to change, bit 0 = register 1 bit 0 |
| value_i | input | 16 | Target values for the masked bits |
| nonvol_i | input | 1 | 1 = persistent update, 0 = volatile update |
| cmd_valid_o | output | 1 | Command request to the engine |
| cmd_ready_i | input | 1 | Engine accepts the request |
| cmd_op_o | output | 8 | Command opcode |
| cmd_wdata_o | output | 16 | Data to send, bits 7:0 first |
| cmd_wbytes_o | output | 2 | Number of data bytes to send |
| cmd_rbyte_o | output | 1 | 1 = one response byte expected |
| rsp_valid_i | input | 1 | Response beat for the accepted command |
| rsp_err_i | input | 1 | The command failed |
| rsp_data_i | input | 8 | Byte read by the command |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| error_o | output | 1 | Last sequence failed |
| locked_o | output | 1 | Last sequence found masked bits unwritable |

## Verification
The bench targets the early exit when the masked bits already match: a block that missed it would send an extra enable and write, which the command-order comparison flags. It covers both enable opcodes and swapped byte order in the write word, either of which corrupts the emulated flash word. It checks a busy flag that stays set past the timeout, a settle gap after a volatile write, and write-protected bits that must surface as locked rather than as success. Injected failures on several command positions, a stalling ready line and a stray second start probe early aborts and the request hold rules.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int unsigned SR_W   = 8;
    localparam int unsigned WORD_W = 2 * SR_W;
    localparam int unsigned OP_W   = 8;

    localparam logic [OP_W-1:0] OP_RD_LO  = 8'h05;
    localparam logic [OP_W-1:0] OP_RD_HI  = 8'h35;
    localparam logic [OP_W-1:0] OP_EN_NV  = 8'h06;
    localparam logic [OP_W-1:0] OP_EN_VOL = 8'h50;
    localparam logic [OP_W-1:0] OP_WR_SR  = 8'h01;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_LO,
        S_RD_HI,
        S_ENABLE,
        S_WRITE,
        S_POLL,
        S_SETTLE,
        S_VRF_LO,
        S_VRF_HI
    } seq_state_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_REQ,
        P_RSP
    } port_state_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [WORD_W-1:0] wdata;
        logic [1:0]        wbytes;
        logic              rbyte;
    } cmd_t;

endpackage

// File: rtl/sreg_countdown.sv
module sreg_countdown #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // a freshly loaded nonzero count is never reported as expired
    AST_LOAD_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && val_i != '0) |=> !zero_o);  // R8

endmodule

// File: rtl/sreg_cmd_port.sv
module sreg_cmd_port
    import sreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  cmd_t            cmd_i,
    output logic            idle_o,
    output logic            eng_valid_o,
    output cmd_t            eng_cmd_o,
    input  logic            eng_ready_i,
    input  logic            eng_rsp_valid_i,
    input  logic            eng_rsp_err_i,
    input  logic [SR_W-1:0] eng_rsp_data_i,
    output logic            fin_o,
    output logic            fail_o,
    output logic [SR_W-1:0] rdata_o
);

    typedef struct packed {
        port_state_t st;
        cmd_t        cmd;
    } port_t;

    port_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            P_IDLE: begin
                if (issue_i) begin
                    d.st  = P_REQ;
                    d.cmd = cmd_i;
                end
            end
            P_REQ: begin
                if (eng_ready_i) begin
                    d.st = P_RSP;
                end
            end
            P_RSP: begin
                if (eng_rsp_valid_i) begin
                    d.st = P_IDLE;
                end
            end
            default: d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: P_IDLE, cmd: '0};
        end else begin
            q <= d;
        end
    end

    assign idle_o      = (q.st == P_IDLE);
    assign eng_valid_o = (q.st == P_REQ);
    assign eng_cmd_o   = q.cmd;
    assign fin_o       = (q.st == P_RSP) && eng_rsp_valid_i;
    assign fail_o      = fin_o && eng_rsp_err_i;
    assign rdata_o     = eng_rsp_data_i;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid_o && !eng_ready_i) |=> (eng_valid_o && $stable(eng_cmd_o)));  // R11

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid_o && eng_ready_i) |=> !eng_valid_o);  // R11

endmodule

// File: rtl/sreg_update_seq.sv
module sreg_update_seq
    import sreg_pkg::*;
#(
    parameter int unsigned DELAY_CYCLES = 50,
    parameter int unsigned POLL_TIMEOUT = 100000,
    parameter int unsigned BUSY_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] mask_i,
    input  logic [WORD_W-1:0] value_i,
    input  logic              nonvol_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [OP_W-1:0]   cmd_op_o,
    output logic [WORD_W-1:0] cmd_wdata_o,
    output logic [1:0]        cmd_wbytes_o,
    output logic              cmd_rbyte_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_err_i,
    input  logic [SR_W-1:0]   rsp_data_i,
    output logic              done_o,
    output logic              error_o,
    output logic              locked_o
);

    localparam int unsigned LONGEST = (DELAY_CYCLES > POLL_TIMEOUT) ? DELAY_CYCLES : POLL_TIMEOUT;
    localparam int unsigned TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] T_POLL   = TW'(POLL_TIMEOUT);
    localparam logic [TW-1:0] T_SETTLE = TW'(DELAY_CYCLES);

    typedef struct packed {
        seq_state_t        st;
        logic              pend;
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] nw;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] val;
        logic              nonvol;
        logic              done;
        logic              err;
        logic              lock;
    } seq_t;

    seq_t d, q;

    cmd_t            cmd;
    cmd_t            eng_cmd;
    logic            issue;
    logic            port_idle;
    logic            fin;
    logic            fail;
    logic [SR_W-1:0] rdata;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_zero;
    logic [WORD_W-1:0] joined;

    assign joined = {rdata, q.cur[SR_W-1:0]};

    always_comb begin
        d      = q;
        d.done = 1'b0;
        issue  = 1'b0;
        t_load = 1'b0;
        t_val  = T_SETTLE;
        cmd    = '{op: OP_RD_LO, wdata: '0, wbytes: 2'd0, rbyte: 1'b1};

        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.st     = S_RD_LO;
                    d.pend   = 1'b0;
                    d.mask   = mask_i;
                    d.val    = value_i;
                    d.nonvol = nonvol_i;
                    d.err    = 1'b0;
                    d.lock   = 1'b0;
                end
            end

            S_RD_LO, S_VRF_LO: begin
                cmd.op = OP_RD_LO;
                if (!q.pend) begin
                    issue  = 1'b1;
                    d.pend = 1'b1;
                end else if (fin) begin
                    d.pend = 1'b0;
                    if (fail) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.cur[SR_W-1:0] = rdata;
                        d.st = (q.st == S_RD_LO) ? S_RD_HI : S_VRF_HI;
                    end
                end
            end

            S_RD_HI: begin
                cmd.op = OP_RD_HI;
                if (!q.pend) begin
                    issue  = 1'b1;
                    d.pend = 1'b1;
                end else if (fin) begin
                    d.pend = 1'b0;
                    if (fail) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.cur = joined;
                        if (((joined ^ q.val) & q.mask) == '0) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.nw = (joined & ~q.mask) | (q.val & q.mask);
                            d.st = S_ENABLE;
                        end
                    end
                end
            end

            S_ENABLE: begin
                cmd.op    = q.nonvol ? OP_EN_NV : OP_EN_VOL;
                cmd.rbyte = 1'b0;
                if (!q.pend) begin
                    issue  = 1'b1;
                    d.pend = 1'b1;
                end else if (fin) begin
                    d.pend = 1'b0;
                    if (fail) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st = S_WRITE;
                    end
                end
            end

            S_WRITE: begin
                cmd.op     = OP_WR_SR;
                cmd.wdata  = q.nw;
                cmd.wbytes = 2'd2;
                cmd.rbyte  = 1'b0;
                if (!q.pend) begin
                    issue  = 1'b1;
                    d.pend = 1'b1;
                end else if (fin) begin
                    d.pend = 1'b0;
                    if (fail) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        t_load = 1'b1;
                        if (q.nonvol) begin
                            t_val = T_POLL;
                            d.st  = S_POLL;
                        end else begin
                            t_val = T_SETTLE;
                            d.st  = S_SETTLE;
                        end
                    end
                end
            end

            S_POLL: begin
                cmd.op = OP_RD_LO;
                if (!q.pend) begin
                    issue  = 1'b1;
                    d.pend = 1'b1;
                end else if (fin) begin
                    d.pend = 1'b0;
                    if (fail) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else if (!rdata[BUSY_BIT]) begin
                        d.st = S_VRF_LO;
                    end else if (t_zero) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end
                end
            end

            S_SETTLE: begin
                if (t_zero) begin
                    d.st = S_VRF_LO;
                end
            end

            S_VRF_HI: begin
                cmd.op = OP_RD_HI;
                if (!q.pend) begin
                    issue  = 1'b1;
                    d.pend = 1'b1;
                end else if (fin) begin
                    d.pend = 1'b0;
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    if (fail) begin
                        d.err = 1'b1;
                    end else if (((joined ^ q.val) & q.mask) != '0) begin
                        d.err  = 1'b1;
                        d.lock = 1'b1;
                    end
                end
            end

            default: begin
                d.st   = S_IDLE;
                d.pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    sreg_cmd_port u_port (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_i         (issue),
        .cmd_i           (cmd),
        .idle_o          (port_idle),
        .eng_valid_o     (cmd_valid_o),
        .eng_cmd_o       (eng_cmd),
        .eng_ready_i     (cmd_ready_i),
        .eng_rsp_valid_i (rsp_valid_i),
        .eng_rsp_err_i   (rsp_err_i),
        .eng_rsp_data_i  (rsp_data_i),
        .fin_o           (fin),
        .fail_o          (fail),
        .rdata_o         (rdata)
    );

    sreg_countdown #(.W(TW)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    assign cmd_op_o     = eng_cmd.op;
    assign cmd_wdata_o  = eng_cmd.wdata;
    assign cmd_wbytes_o = eng_cmd.wbytes;
    assign cmd_rbyte_o  = eng_cmd.rbyte;
    assign done_o       = q.done;
    assign error_o      = q.err;
    assign locked_o     = q.lock;

    AST_ISSUE_TO_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> port_idle);  // R11

    AST_LOCK_WITH_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> error_o);  // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R12

    AST_WRITE_WORD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_op_o == OP_WR_SR)
            |-> (((cmd_wdata_o ^ q.val) & q.mask) == '0 && cmd_wbytes_o == 2'd2));  // R5

    AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SETTLE && !t_zero) |=> (q.st == S_SETTLE));  // R8

    AST_FAIL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (q.st == S_IDLE && error_o && !locked_o));  // R10

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE && start_i) |=> ($stable(q.mask) && $stable(q.val)));  // R12

endmodule

// File: tb/tb_sreg_update_seq.sv
module tb_sreg_update_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 20;
    localparam int TMO        = 300;
    localparam int WAIT_LIMIT = 6000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [15:0] value_i = '0;
    logic        nonvol_i = 1'b0;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b0;
    logic [7:0]  cmd_op_o;
    logic [15:0] cmd_wdata_o;
    logic [1:0]  cmd_wbytes_o;
    logic        cmd_rbyte_o;
    logic        rsp_valid_i = 1'b0;
    logic        rsp_err_i = 1'b0;
    logic [7:0]  rsp_data_i = '0;
    logic        done_o;
    logic        error_o;
    logic        locked_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sreg_update_seq #(.DELAY_CYCLES(DLY), .POLL_TIMEOUT(TMO), .BUSY_BIT(0)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .value_i(value_i), .nonvol_i(nonvol_i), .cmd_valid_o(cmd_valid_o),
        .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o), .cmd_wdata_o(cmd_wdata_o),
        .cmd_wbytes_o(cmd_wbytes_o), .cmd_rbyte_o(cmd_rbyte_o),
        .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .rsp_data_i(rsp_data_i),
        .done_o(done_o), .error_o(error_o), .locked_o(locked_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // emulated flash and command engine
    logic [15:0] sr = 16'h0000;
    logic        wel = 1'b0;
    logic        vwel = 1'b0;
    int          busy_left = 0;
    bit          busy_hold = 0;
    int          cfg_busy = 0;
    bit          cfg_forever = 0;
    int          cfg_err_at = -1;
    logic [15:0] cfg_lockm = '0;
    bit          cfg_stall = 0;
    bit          cfg_nv = 0;
    int          txn = 0;
    int          cyc = 0;
    int          rsp_cnt = 0;
    logic [7:0]  p_op = '0;
    logic [7:0]  p_data = '0;
    logic        p_err = 1'b0;
    int          wr_rsp_cyc = 0;
    bit          gap_pend = 0;
    bit          poll_any = 0;
    int          poll_seen = 0;

    logic [23:0] expq[$];
    string       tagq[$];

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            cmd_ready_i = 1'b0;
            rsp_valid_i = 1'b0;
        end else begin
            if (rsp_valid_i) begin
                rsp_valid_i = 1'b0;
                rsp_err_i   = 1'b0;
            end else if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_err_i   = p_err;
                    rsp_data_i  = p_data;
                    if (p_op == 8'h01 && !p_err) begin
                        wr_rsp_cyc = cyc;
                        gap_pend   = !cfg_nv;
                    end
                end
            end
            cmd_ready_i = cfg_stall ? ((cyc % 3) != 0) : 1'b1;
            if (cmd_valid_o && cmd_ready_i) begin
                p_op   = cmd_op_o;
                p_err  = (txn == cfg_err_at);
                p_data = '0;
                if (gap_pend) begin
                    chk("R8", "settle gap long enough", 32'((cyc - wr_rsp_cyc) >= DLY), 1);
                    gap_pend = 0;
                end
                if (expq.size() > 0) begin
                    logic [23:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(t, "opcode", 32'(cmd_op_o), 32'(e[23:16]));
                    if (e[23:16] == 8'h01) begin
                        chk("R5", "write word", 32'(cmd_wdata_o), 32'(e[15:0]));
                        chk("R5", "write byte count", 32'(cmd_wbytes_o), 2);
                    end
                end else if (poll_any) begin
                    chk("R7", "poll opcode", 32'(cmd_op_o), 32'h05);
                    poll_seen++;
                end else begin
                    chk("R10", "unexpected command", 32'(cmd_op_o), 32'h100);
                end
                if (!p_err) begin
                    case (cmd_op_o)
                        8'h05: begin
                            p_data = {sr[7:1], (busy_hold || busy_left > 0)};
                            if (busy_left > 0) busy_left--;
                        end
                        8'h35: p_data = sr[15:8];
                        8'h06: wel = 1'b1;
                        8'h50: vwel = 1'b1;
                        8'h01: begin
                            if (wel || vwel) begin
                                sr = (cmd_wdata_o & ~cfg_lockm & 16'hFFFE) | (sr & (cfg_lockm | 16'h0001));
                                if (wel) begin
                                    busy_left = cfg_busy;
                                    busy_hold = cfg_forever;
                                end
                            end
                            wel  = 1'b0;
                            vwel = 1'b0;
                        end
                        default: ;
                    endcase
                end
                rsp_cnt = 1 + (txn % 2);
                txn++;
            end
        end
    end

    task automatic push(input logic [7:0] op, input logic [15:0] wd, input string tag);
        expq.push_back({op, wd});
        tagq.push_back(tag);
    endtask

    task automatic run(input string name, input logic [15:0] m, input logic [15:0] v, input bit nv,
                       input int busy_polls, input bit forever_busy, input int err_idx,
                       input logic [15:0] lockm, input bit stall, input bit extra_start);
        logic [15:0] cur, nw, stored, sr_before;
        bit exp_err, exp_lock, wrote;
        int k;
        string rtag;
        cfg_busy = busy_polls; cfg_forever = forever_busy; cfg_err_at = err_idx;
        cfg_lockm = lockm; cfg_stall = stall; cfg_nv = nv;
        txn = 0; poll_any = 0; poll_seen = 0; gap_pend = 0;
        expq.delete(); tagq.delete();
        cur = sr; sr_before = sr; nw = cur; stored = cur;
        exp_err = 0; exp_lock = 0; wrote = 0;
        rtag = "R3";
        push(8'h05, 16'h0, "R2");
        push(8'h35, 16'h0, "R2");
        if (((cur ^ v) & m) != 0) begin
            wrote = 1;
            rtag = "R9";
            nw = (cur & ~m) | (v & m);
            push(nv ? 8'h06 : 8'h50, 16'h0, "R4");
            push(8'h01, nw, "R5");
            stored = (nw & ~lockm & 16'hFFFE) | (cur & (lockm | 16'h0001));
            if (nv && forever_busy) begin
                poll_any = 1; exp_err = 1; rtag = "R7";
            end else begin
                if (nv) for (int i = 0; i <= busy_polls; i++) push(8'h05, 16'h0, "R6");
                push(8'h05, 16'h0, "R9");
                push(8'h35, 16'h0, "R9");
                if (((stored ^ v) & m) != 0) begin exp_err = 1; exp_lock = 1; end
            end
        end
        if (err_idx >= 0) begin
            while (expq.size() > err_idx + 1) begin void'(expq.pop_back()); void'(tagq.pop_back()); end
            exp_err = 1; exp_lock = 0; poll_any = 0; rtag = "R10";
            if (err_idx < 3) wrote = 0;
        end
        @(negedge clk);
        mask_i = m; value_i = v; nonvol_i = nv; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        while (!done_o && k < WAIT_LIMIT) begin
            @(negedge clk);
            k++;
            if (extra_start && k == 4) begin
                start_i = 1'b1; mask_i = ~m; value_i = ~v; nonvol_i = ~nv;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        if (k >= WAIT_LIMIT) chk("R12", {name, " done seen"}, 0, 1);
        chk(rtag, {name, " error"}, 32'(error_o), 32'(exp_err));
        chk(rtag, {name, " locked"}, 32'(locked_o), 32'(exp_lock));
        chk("R2", {name, " all commands issued"}, expq.size(), 0);
        if (poll_any) begin
            chk("R7", {name, " timeout elapsed"}, 32'((cyc - wr_rsp_cyc) >= TMO), 1);
            chk("R7", {name, " polled"}, 32'(poll_seen > 0), 1);
        end
        if (!wrote) chk("R3", {name, " flash untouched"}, 32'(sr), 32'(sr_before));
        else if (err_idx < 0 || err_idx > 3) chk("R5", {name, " flash word"}, 32'(sr), 32'(stored));
        @(negedge clk);
        chk("R12", {name, " done one cycle"}, 32'(done_o), 0);
        repeat (4) @(negedge clk);
        chk("R12", {name, " error held"}, 32'(error_o), 32'(exp_err));
        chk("R12", {name, " locked held"}, 32'(locked_o), 32'(exp_lock));
        chk("R10", {name, " no stray request"}, 32'(cmd_valid_o), 0);
        busy_hold = 0; busy_left = 0; cfg_forever = 0; cfg_err_at = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(cmd_valid_o), 0);
        chk("R1", "done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", "valid idle", 32'(cmd_valid_o), 0);
        chk("R1", "flags idle", {29'd0, done_o, error_o, locked_o}, 0);

        run("persist",      16'h003C, 16'h0028, 1, 3, 0, -1, 16'h0000, 0, 0);
        run("already set",  16'h003C, 16'h0028, 1, 0, 0, -1, 16'h0000, 0, 0);
        run("volatile",     16'hC000, 16'h4000, 0, 0, 0, -1, 16'h0000, 1, 0);
        run("protected",    16'h0C04, 16'h0804, 1, 1, 0, -1, 16'h0C00, 0, 0);
        run("busy forever", 16'h0002, 16'h0002, 1, 0, 1, -1, 16'h0000, 0, 0);
        run("fail reg2",    16'h0100, 16'h0100, 0, 0, 0, 1,  16'h0000, 0, 0);
        run("fail write",   16'h0100, 16'h0100, 1, 0, 0, 3,  16'h0000, 1, 0);
        run("fail enable",  16'h0100, 16'h0100, 0, 0, 0, 2,  16'h0000, 0, 0);
        run("fail first",   16'h0100, 16'h0100, 1, 0, 0, 0,  16'h0000, 1, 0);
        run("second start", 16'h00F0, 16'h0050, 0, 0, 0, -1, 16'h0000, 0, 1);
        run("high byte nv", 16'hFF00, 16'h5A00, 1, 2, 0, -1, 16'h0000, 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule